// File: doc/BRIEF.md
# Word-to-halfword/byte lane splitter

This block sits between a wide FIFO read port and a narrower output port. It takes a 36-bit word from upstream and delivers it on an 18-bit port in consecutive pieces. In halfword mode each word becomes two 18-bit lanes. In byte mode each word becomes four 9-bit lanes, and each byte sits on the low 9 bits of the port.

The downstream reader pulls lanes with a read enable. Upstream words arrive on a valid/ready handshake. A new word is taken only once the last lane of the held word is read. When a word is waiting upstream at that moment, the handover costs no idle cycle.

Two inputs are sampled while reset is held: the lane size and the lane order. The lane order is either most-significant lane first or least-significant lane first. Both settings stay fixed until the next reset, whatever those inputs do in between.

Top module: `lane_splitter`

## Requirements
- R1: Halfword mode with most-significant-first order (size input 0, order input 0) delivers word bits 35:18 first, then bits 17:0.
- R2: Halfword mode with least-significant-first order (size input 0, order input 1) delivers bits 17:0 first, then bits 35:18.
- R3: Byte mode with most-significant-first order (size input 1, order input 0) delivers bits 35:27, 26:18, 17:9, 8:0 in that order, each on out_data[8:0].
- R4: Byte mode with least-significant-first order (size input 1, order input 1) delivers bits 8:0, 17:9, 26:18, 35:27 in that order, each on out_data[8:0].
- R5: In byte mode out_data[17:9] is zero while out_valid is high.
- R6: Lane size and order are taken from their inputs while rst_n is low. Changing those inputs after reset has no effect on the output sequence.
- R7: out_valid is low whenever no word is held. A read made while out_valid is low neither consumes nor skips a lane: the next word loaded starts at its first lane.
- R8: in_ready is high when no word is held. While a word is held, in_ready is high only in a cycle that reads its last lane.
- R9: Reset discards a partly read word: out_valid goes low, and the next word loaded starts at its first lane.
- R10: If a word is offered upstream in the cycle that reads the last lane, it is loaded on that edge. out_valid then stays high and the new word's first lane appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is sampled while it is low |
| cfg_byte | input | 1 | Lane size: 0 selects halfword lanes, 1 selects byte lanes |
| cfg_little | input | 1 | Lane order: 0 sends the most significant lane first, 1 sends the least significant lane first |
| in_word | input | 36 | Word from upstream |
| in_valid | input | 1 | Upstream word is present |
| in_ready | output | 1 | Block accepts in_word on this edge |
| rd_en | input | 1 | Downstream read of the current lane |
| out_data | output | 18 | Current lane; byte lanes use bits 8:0 |
| out_valid | output | 1 | A word is held and out_data carries its current lane |

## Verification
Each of the four size/order settings is tried with a walking-one word for every one of the 36 bit positions. A single set bit shows up in exactly one lane at one position, so any lane swap, offset error or order error is detected. A chain of pseudo-random words is then sent with no gap, to test the handover on the last read. Reads are issued while the block is empty, and a reset is applied in the middle of a word. In both cases the next word must still begin with its first lane. After each reset the configuration inputs are flipped, so any late sampling of size or order would change the observed sequence.

// File: rtl/lane_split_pkg.sv
package lane_split_pkg;

   typedef enum logic {
      SIZE_HALF = 1'b0,
      SIZE_BYTE = 1'b1
   } lane_size_e;

   typedef enum logic {
      ORDER_MSB_FIRST = 1'b0,
      ORDER_LSB_FIRST = 1'b1
   } lane_order_e;

   typedef struct packed {
      lane_size_e  size;
      lane_order_e order;
   } split_cfg_t;

endpackage

// File: rtl/lane_cfg_latch.sv
module lane_cfg_latch
   import lane_split_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       size_in,
   input  logic       order_in,
   output split_cfg_t cfg
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg.size  <= lane_size_e'(size_in);
         cfg.order <= lane_order_e'(order_in);
      end
   end

   // configuration only moves while reset is held
   assert_cfg_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(cfg));

endmodule

// File: rtl/lane_seq.sv
module lane_seq #(
   parameter int HALF_LANES = 2,
   parameter int BYTE_LANES = 4,
   localparam int CNT_W     = $clog2(BYTE_LANES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_mode,
   input  logic             in_valid,
   input  logic             rd_en,
   output logic             held,
   output logic [CNT_W-1:0] lane,
   output logic             in_ready,
   output logic             load
);

   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_LANES - 1);
   localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_LANES - 1);

   logic             rd_fire;
   logic             wrap;
   logic [CNT_W-1:0] last_idx;

   assign last_idx = byte_mode ? BYTE_LAST : HALF_LAST;
   assign rd_fire  = rd_en && held;
   assign wrap     = rd_fire && (lane == last_idx);
   assign in_ready = !held || wrap;
   assign load     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held <= 1'b0;
         lane <= '0;
      end else if (load) begin
         held <= 1'b1;
         lane <= '0;
      end else if (wrap) begin
         held <= 1'b0;
         lane <= '0;
      end else if (rd_fire) begin
         lane <= lane + 1'b1;
      end
   end

   assert_empty_read_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!held && !in_valid) |=> (!held && lane == '0));

   assert_lane_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      held |-> (lane <= last_idx));

   assert_hold_without_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !rd_en) |=> (held && $stable(lane)));

   assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!held && lane == '0));

   assert_load_first_lane_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (held && lane == '0));

endmodule

// File: rtl/lane_mux.sv
module lane_mux #(
   parameter int WORD_W     = 36,
   parameter int PORT_W     = 18,
   localparam int BYTE_W    = PORT_W / 2,
   localparam int HALF_LANES = WORD_W / PORT_W,
   localparam int BYTE_LANES = WORD_W / BYTE_W,
   localparam int CNT_W     = $clog2(BYTE_LANES),
   localparam int HALF_IW   = $clog2(HALF_LANES)
) (
   input  logic [WORD_W-1:0] word,
   input  logic [CNT_W-1:0]  lane,
   input  logic              byte_mode,
   input  logic              lsb_first,
   output logic [PORT_W-1:0] data
);

   logic [PORT_W-1:0] half_arr [HALF_LANES];
   logic [BYTE_W-1:0] byte_arr [BYTE_LANES];
   logic [HALF_IW-1:0] half_idx;
   logic [CNT_W-1:0]   byte_idx;

   for (genvar g = 0; g < HALF_LANES; g++) begin : g_half
      assign half_arr[g] = word[g*PORT_W +: PORT_W];
   end

   for (genvar g = 0; g < BYTE_LANES; g++) begin : g_byte
      assign byte_arr[g] = word[g*BYTE_W +: BYTE_W];
   end

   assign half_idx = lsb_first ? lane[HALF_IW-1:0]
                               : HALF_IW'(HALF_LANES - 1) - lane[HALF_IW-1:0];
   assign byte_idx = lsb_first ? lane : CNT_W'(BYTE_LANES - 1) - lane;

   assign data = byte_mode ? {{(PORT_W - BYTE_W){1'b0}}, byte_arr[byte_idx]}
                           : half_arr[half_idx];

endmodule

// File: rtl/lane_splitter.sv
module lane_splitter
   import lane_split_pkg::*;
#(
   parameter int WORD_W = 36,
   parameter int PORT_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_byte,
   input  logic              cfg_little,
   input  logic [WORD_W-1:0] in_word,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              rd_en,
   output logic [PORT_W-1:0] out_data,
   output logic              out_valid
);

   localparam int BYTE_W     = PORT_W / 2;
   localparam int HALF_LANES = WORD_W / PORT_W;
   localparam int BYTE_LANES = WORD_W / BYTE_W;
   localparam int CNT_W      = $clog2(BYTE_LANES);

   if (PORT_W % 2 != 0) begin : g_bad_port
      $error("PORT_W must be even so a byte is half a port");
   end
   if (WORD_W % PORT_W != 0 || HALF_LANES < 2) begin : g_bad_word
      $error("WORD_W must be a multiple of PORT_W, at least twice as wide");
   end
   if ((1 << CNT_W) != BYTE_LANES) begin : g_bad_count
      $error("lane count must be a power of two");
   end

   split_cfg_t        cfg;
   logic              held;
   logic [CNT_W-1:0]  lane;
   logic              load;
   logic [WORD_W-1:0] word_q;

   lane_cfg_latch u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .size_in  (cfg_byte),
      .order_in (cfg_little),
      .cfg      (cfg)
   );

   lane_seq #(
      .HALF_LANES (HALF_LANES),
      .BYTE_LANES (BYTE_LANES)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_mode (cfg.size == SIZE_BYTE),
      .in_valid  (in_valid),
      .rd_en     (rd_en),
      .held      (held),
      .lane      (lane),
      .in_ready  (in_ready),
      .load      (load)
   );

   always_ff @(posedge clk) begin
      if (load) begin
         word_q <= in_word;
      end
   end

   lane_mux #(
      .WORD_W (WORD_W),
      .PORT_W (PORT_W)
   ) u_mux (
      .word      (word_q),
      .lane      (lane),
      .byte_mode (cfg.size == SIZE_BYTE),
      .lsb_first (cfg.order == ORDER_LSB_FIRST),
      .data      (out_data)
   );

   assign out_valid = held;

   assert_byte_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cfg.size == SIZE_BYTE) |-> (out_data[PORT_W-1:BYTE_W] == '0));

   assert_lane_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !rd_en) |=> (out_valid && $stable(out_data)));

   assert_handover_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   assert_ready_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

endmodule

// File: tb/lane_splitter_bench.sv
module lane_splitter_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_byte;
   logic        cfg_little;
   logic [35:0] in_word;
   logic        in_valid;
   logic        in_ready;
   logic        rd_en;
   logic [17:0] out_data;
   logic        out_valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   lane_splitter u_lane_splitter (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_byte   (cfg_byte),
      .cfg_little (cfg_little),
      .in_word    (in_word),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .rd_en      (rd_en),
      .out_data   (out_data),
      .out_valid  (out_valid)
   );

   task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [17:0] exp_lane(logic [35:0] w, int k, bit b, bit le);
      int n;
      int idx;
      logic [35:0] sh;
      n   = b ? 4 : 2;
      idx = le ? k : n - 1 - k;
      if (b) begin
         sh = w >> (idx * 9);
         return {9'd0, sh[8:0]};
      end
      sh = w >> (idx * 18);
      return sh[17:0];
   endfunction

   function automatic string order_tag(bit b, bit le);
      if (b) return le ? "R4" : "R3";
      return le ? "R2" : "R1";
   endfunction

   // configuration inputs are flipped after release to exercise R6
   task automatic do_reset(input bit b, input bit le);
      @(negedge clk);
      rst_n = 1'b0; cfg_byte = b; cfg_little = le; in_valid = 1'b0; rd_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      cfg_byte = ~b; cfg_little = ~le;
      #1;
      chk("R9 out_valid after reset", {35'd0, out_valid}, 36'd0);
      chk("R8 in_ready after reset", {35'd0, in_ready}, 36'd1);
   endtask

   task automatic load_word(input logic [35:0] w);
      in_valid = 1'b1; in_word = w;
      #1 chk("R8 in_ready while empty", {35'd0, in_ready}, 36'd1);
      @(negedge clk);
      in_valid = 1'b0;
      #1 chk("R7 out_valid after load", {35'd0, out_valid}, 36'd1);
   endtask

   task automatic drain(input logic [35:0] w, input bit b, input bit le,
                        input bit chain, input logic [35:0] nxt);
      int n;
      n = b ? 4 : 2;
      for (int k = 0; k < n; k++) begin
         #1;
         chk({order_tag(b, le), " R6 lane data"}, {18'd0, out_data}, {18'd0, exp_lane(w, k, b, le)});
         if (b) chk("R5 upper bits zero", {27'd0, out_data[17:9]}, 36'd0);
         rd_en = 1'b1;
         if (k == n - 1) begin
            if (chain) begin
               in_valid = 1'b1; in_word = nxt;
            end
            #1 chk("R8 in_ready on last read", {35'd0, in_ready}, 36'd1);
         end else begin
            #1 chk("R8 in_ready mid word", {35'd0, in_ready}, 36'd0);
         end
         @(negedge clk);
         rd_en = 1'b0; in_valid = 1'b0;
      end
      #1 chk("R10 out_valid after last lane", {35'd0, out_valid}, {35'd0, chain});
   endtask

   initial begin
      logic [35:0] lfsr;
      logic [35:0] prev;
      rst_n = 1'b0; cfg_byte = 1'b0; cfg_little = 1'b0;
      in_word = '0; in_valid = 1'b0; rd_en = 1'b0;
      for (int c = 0; c < 4; c++) begin
         bit b  = c[1];
         bit le = c[0];
         do_reset(b, le);
         // walking one across every bit position
         for (int i = 0; i < 36; i++) begin
            load_word(36'd1 << i);
            drain(36'd1 << i, b, le, 1'b0, 36'd0);
         end
         load_word(36'h9_A5C3_7E12);
         drain(36'h9_A5C3_7E12, b, le, 1'b0, 36'd0);
         // reads while empty must not move the lane position (R7)
         rd_en = 1'b1;
         repeat (3) begin
            @(negedge clk);
            #1 chk("R7 out_valid while empty", {35'd0, out_valid}, 36'd0);
         end
         rd_en = 1'b0;
         load_word(36'h1_2345_6789);
         drain(36'h1_2345_6789, b, le, 1'b0, 36'd0);
         // back-to-back chain of pseudo-random words (R10)
         lfsr = 36'h8_1F2E_3D4C + 36'(c);
         load_word(lfsr);
         for (int j = 0; j < 8; j++) begin
            prev = lfsr;
            lfsr = {lfsr[34:0], lfsr[35] ^ lfsr[24]} ^ 36'h3_0000_0101;
            drain(prev, b, le, j != 7, lfsr);
         end
         // reset part way through a word (R9)
         load_word(36'hF_0F0F_0F0F);
         #1;
         rd_en = 1'b1;
         @(negedge clk);
         rd_en = 1'b0;
         do_reset(b, le);
         load_word(36'h5_5AA5_3CC3);
         drain(36'h5_5AA5_3CC3, b, le, 1'b0, 36'd0);
      end
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog all requirements actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule